// File: doc/BRIEF.md
# Fan Speed Start-Up Sequencer

This block takes an 8-bit fan speed setting, written through a single-cycle write strobe, and drives four fan control lines. Three of them are an active-low speed select and one is an active-low shutdown line. When the fan is off and a nonzero speed is written, the block first runs the fan at full speed for a start-up interval, so that the fan spins up reliably even when a low speed is requested. Only after that interval do the select lines follow the stored setting.

The select lines and the shutdown line move in a fixed order, separated by half of the start-up interval. At turn-on the select lines go to full speed first, and the shutdown line releases half an interval later. At turn-off, started by writing zero, the shutdown line asserts first, and the select lines return to idle half an interval later. The start-up interval is a parameter counted in clock cycles. A timer-enable output is high only while the interval timer runs, which models powering the oscillator up and down.

A zero written during the start-up kick cancels the kick and starts the turn-off sequence. A nonzero write during the turn-off wait starts the full turn-on sequence again. A new nonzero value written while the fan is running takes effect at once, with no kick.

Top module: `fan_start_seq`

## Requirements
- R1: After a synchronous reset the speed setting is zero and the fan is off: `fan_sel_n` is 3'b111, `fan_off_n` is 0 and `tmr_en` is 0.
- R2: A nonzero write while the fan is off sets `fan_sel_n` to 3'b000 (full speed), keeps `fan_off_n` at 0 and sets `tmr_en` to 1 in the cycle after the write edge.
- R3: `fan_off_n` rises exactly T_START/2 cycles after that first kick cycle, while `fan_sel_n` is still 3'b000.
- R4: The kick lasts T_START cycles. After it, `fan_sel_n` equals the inverted low 3 bits of the stored setting, `fan_off_n` is 1 and `tmr_en` is 0.
- R5: A nonzero write while the fan runs after the kick updates `fan_sel_n` in the next cycle, with no kick and no timer activity.
- R6: A nonzero write during the kick changes the stored setting but does not shorten or restart the kick. The last value written is applied when the kick ends.
- R7: A zero write while the fan runs drives `fan_off_n` low in the next cycle, leaves `fan_sel_n` unchanged and sets `tmr_en`. T_START/2 cycles later `fan_sel_n` returns to 3'b111 and `tmr_en` falls.
- R8: A zero write during the kick begins the turn-off wait at once. `fan_sel_n` holds 3'b000 through the wait and then returns to 3'b111.
- R9: A nonzero write during the turn-off wait restarts the full turn-on sequence of R2 to R4, measured from that write.
- R10: A zero write while the fan is off changes no output.
- R11: `tmr_en` is high only during the kick and the turn-off wait.
- R12: `wr_data` has no effect while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the speed setting |
| wr_data | input | 8 | Speed setting value written on `wr_en` |
| fan_sel_n | output | 3 | Active-low speed select (3'b000 is full speed, 3'b111 is idle) |
| fan_off_n | output | 1 | Active-low shutdown line (0 means the fan is shut down) |
| tmr_en | output | 1 | High while the interval timer runs |

## Verification
The embedded assertions check the ordering rules on every cycle:
- The shutdown line only releases while the select lines sit at full speed.
- The shutdown line never asserts in the same cycle the select lines move.
- The idle select pattern holds whenever the fan is shut down with the timer stopped.
- A write from off always enters the kick.
- The interval counter stays inside its range.

Only the bench scenarios can show the exact cycles:
- the half-interval and full-interval boundaries;
- the value applied after a kick overwritten mid-way;
- the abort and restart paths;
- that a strobe-less write or a zero written while off leaves the outputs alone.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_FULL = '0;
    localparam logic [SEL_W-1:0] SEL_IDLE = '1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_KICK = 2'd1,
        ST_RUN  = 2'd2,
        ST_STOP = 2'd3
    } fan_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel_n;
        logic             off_n;
        logic             tmr;
    } fan_drive_t;

    function automatic logic [SEL_W-1:0] sel_from_speed(input logic [SEL_W-1:0] spd_low);
        return ~spd_low;
    endfunction

endpackage

// File: rtl/fan_seq_timer.sv
module fan_seq_timer #(
    parameter int T_START = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic at_half_end,
    output logic at_full_end,
    output logic past_half
);
    localparam int HALF = T_START / 2;
    localparam int CW   = $clog2(T_START + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && (cnt != CW'(T_START - 1))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_half_end = (cnt == CW'(HALF - 1));
    assign at_full_end = (cnt == CW'(T_START - 1));
    assign past_half   = (cnt >= CW'(HALF));

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(T_START));

endmodule

// File: rtl/fan_seq_ctrl.sv
module fan_seq_ctrl
    import fan_seq_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SPD_W-1:0] wr_data,
    input  logic             at_half_end,
    input  logic             at_full_end,
    output fan_state_e       state,
    output logic [SPD_W-1:0] spd_q,
    output logic [SEL_W-1:0] hold_sel,
    output logic             restart
);
    fan_state_e state_nx;
    logic       wr_nz;
    logic       wr_zero;

    assign wr_nz   = wr_en && (|wr_data);
    assign wr_zero = wr_en && !(|wr_data);

    always_comb begin
        state_nx = state;
        restart  = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (wr_nz) begin
                    state_nx = ST_KICK;
                    restart  = 1'b1;
                end
            end
            ST_KICK: begin
                if (wr_zero) begin
                    state_nx = ST_STOP;
                    restart  = 1'b1;
                end else if (at_full_end) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_zero) begin
                    state_nx = ST_STOP;
                    restart  = 1'b1;
                end
            end
            ST_STOP: begin
                if (wr_nz) begin
                    state_nx = ST_KICK;
                    restart  = 1'b1;
                end else if (at_half_end) begin
                    state_nx = ST_OFF;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OFF;
            spd_q    <= '0;
            hold_sel <= SEL_IDLE;
        end else begin
            state <= state_nx;
            if (wr_en) begin
                spd_q <= wr_data;
            end
            if (state_nx == ST_STOP && state != ST_STOP) begin
                hold_sel <= (state == ST_KICK) ? SEL_FULL
                                               : sel_from_speed(spd_q[SEL_W-1:0]);
            end
        end
    end

    assert_run_write_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && wr_nz) |=> (state == ST_RUN));

    assert_stop_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && wr_nz) |=> (state == ST_KICK));

endmodule

// File: rtl/fan_start_seq.sv
module fan_start_seq
    import fan_seq_pkg::*;
#(
    parameter int SPD_W   = 8,
    parameter int T_START = 1_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SPD_W-1:0] wr_data,
    output logic [2:0]       fan_sel_n,
    output logic             fan_off_n,
    output logic             tmr_en
);
    fan_state_e       state;
    logic [SPD_W-1:0] spd_q;
    logic [SEL_W-1:0] hold_sel;
    logic             restart;
    logic             at_half_end;
    logic             at_full_end;
    logic             past_half;
    logic             tmr_run;
    fan_drive_t       drive;

    fan_seq_ctrl #(.SPD_W(SPD_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .at_half_end(at_half_end),
        .at_full_end(at_full_end),
        .state      (state),
        .spd_q      (spd_q),
        .hold_sel   (hold_sel),
        .restart    (restart)
    );

    assign tmr_run = (state == ST_KICK) || (state == ST_STOP);

    fan_seq_timer #(.T_START(T_START)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .run        (tmr_run),
        .at_half_end(at_half_end),
        .at_full_end(at_full_end),
        .past_half  (past_half)
    );

    always_comb begin
        unique case (state)
            ST_KICK: drive = '{sel_n: SEL_FULL, off_n: past_half, tmr: 1'b1};
            ST_RUN:  drive = '{sel_n: sel_from_speed(spd_q[SEL_W-1:0]), off_n: 1'b1, tmr: 1'b0};
            ST_STOP: drive = '{sel_n: hold_sel, off_n: 1'b0, tmr: 1'b1};
            default: drive = '{sel_n: SEL_IDLE, off_n: 1'b0, tmr: 1'b0};
        endcase
    end

    assign fan_sel_n = drive.sel_n;
    assign fan_off_n = drive.off_n;
    assign tmr_en    = drive.tmr;

    assert_kick_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && wr_en && (|wr_data))
            |=> (fan_sel_n == SEL_FULL && !fan_off_n && tmr_en));

    assert_release_at_full_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(fan_off_n) |-> (fan_sel_n == SEL_FULL && tmr_en));

    assert_off_before_sel_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(fan_off_n) |-> $stable(fan_sel_n));

    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !fan_off_n) |-> (fan_sel_n == SEL_IDLE));

endmodule

// File: tb/sim_fan_start_seq.sv
module sim_fan_start_seq;

    localparam int T = 16;
    localparam int H = T / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] fan_sel_n;
    logic       fan_off_n;
    logic       tmr_en;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         c;
        logic [2:0] s;
        logic       sh;
        logic       te;
        string      r;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    fan_start_seq #(.SPD_W(8), .T_START(T)) u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fan_sel_n(fan_sel_n),
        .fan_off_n(fan_off_n),
        .tmr_en   (tmr_en)
    );

    task automatic push(input int c, input logic [2:0] s, input logic sh,
                        input logic te, input string r);
        exp_t e;
        e.c = c; e.s = s; e.sh = sh; e.te = te; e.r = r;
        q.push_back(e);
    endtask

    task automatic wr_start(input logic [7:0] d, output int w);
        wr_en   = 1'b1;
        wr_data = d;
        w       = cyc;
    endtask

    task automatic wr_end();
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'hA5;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].c <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (e.c < cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed, now %0d", e.r, e.c, cyc);
            end else if (fan_sel_n !== e.s || fan_off_n !== e.sh || tmr_en !== e.te) begin
                n_fail++;
                $display("FAIL %s: cycle %0d actual sel=%b off_n=%b tmr=%b expected sel=%b off_n=%b tmr=%b",
                         e.r, cyc, fan_sel_n, fan_off_n, tmr_en, e.s, e.sh, e.te);
            end
        end
    end

    initial begin
        int w, w2, w3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (fan_sel_n !== 3'b111 || fan_off_n !== 1'b0 || tmr_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual sel=%b off_n=%b tmr=%b expected sel=111 off_n=0 tmr=0",
                     fan_sel_n, fan_off_n, tmr_en);
        end

        // R2 R3 R4: turn-on from off with setting 0x05
        wr_start(8'h05, w);
        push(w + 1,     3'b000, 1'b0, 1'b1, "R2");
        push(w + H,     3'b000, 1'b0, 1'b1, "R3");
        push(w + H + 1, 3'b000, 1'b1, 1'b1, "R3");
        push(w + T,     3'b000, 1'b1, 1'b1, "R4");
        push(w + T + 1, 3'b010, 1'b1, 1'b0, "R4");
        wr_end();
        wait_until(w + T + 6);

        // R5: change while running
        wr_start(8'h03, w);
        push(w + 1, 3'b100, 1'b1, 1'b0, "R5");
        push(w + 3, 3'b100, 1'b1, 1'b0, "R5");
        wr_end();
        wait_until(w + 5);

        // R7 R11: turn-off from running
        wr_start(8'h00, w);
        push(w + 1,     3'b100, 1'b0, 1'b1, "R7");
        push(w + H,     3'b100, 1'b0, 1'b1, "R7");
        push(w + H + 1, 3'b111, 1'b0, 1'b0, "R11");
        wr_end();
        wait_until(w + H + 4);

        // R10: zero written while off
        wr_start(8'h00, w);
        push(w + 1, 3'b111, 1'b0, 1'b0, "R10");
        push(w + 4, 3'b111, 1'b0, 1'b0, "R10");
        wr_end();
        wait_until(w + 6);

        // R12: data without strobe
        wr_data = 8'h07;
        w = cyc;
        push(w + 1, 3'b111, 1'b0, 1'b0, "R12");
        push(w + 3, 3'b111, 1'b0, 1'b0, "R12");
        wait_until(w + 5);

        // R6: overwrite during kick
        wr_start(8'h01, w);
        push(w + 1,     3'b000, 1'b0, 1'b1, "R6");
        push(w + 5,     3'b000, 1'b0, 1'b1, "R6");
        push(w + T,     3'b000, 1'b1, 1'b1, "R6");
        push(w + T + 1, 3'b001, 1'b1, 1'b0, "R6");
        wr_end();
        wait_until(w + 4);
        wr_start(8'h06, w2);
        wr_end();
        wait_until(w + T + 4);
        wr_start(8'h00, w);
        push(w + 1,     3'b001, 1'b0, 1'b1, "R7");
        push(w + H + 1, 3'b111, 1'b0, 1'b0, "R11");
        wr_end();
        wait_until(w + H + 4);

        // R8: abort during kick
        wr_start(8'h02, w);
        push(w + 1, 3'b000, 1'b0, 1'b1, "R2");
        wr_end();
        wait_until(w + 3);
        wr_start(8'h00, w2);
        push(w2 + 1,     3'b000, 1'b0, 1'b1, "R8");
        push(w2 + H,     3'b000, 1'b0, 1'b1, "R8");
        push(w2 + H + 1, 3'b111, 1'b0, 1'b0, "R8");
        wr_end();
        wait_until(w2 + H + 4);

        // R9: restart during turn-off wait
        wr_start(8'h04, w);
        wr_end();
        wait_until(w + T + 3);
        wr_start(8'h00, w2);
        push(w2 + 1, 3'b011, 1'b0, 1'b1, "R7");
        wr_end();
        wait_until(w2 + 3);
        wr_start(8'h07, w3);
        push(w3 + 1,     3'b000, 1'b0, 1'b1, "R9");
        push(w3 + H,     3'b000, 1'b0, 1'b1, "R9");
        push(w3 + H + 1, 3'b000, 1'b1, 1'b1, "R9");
        push(w3 + T,     3'b000, 1'b1, 1'b1, "R9");
        push(w3 + T + 1, 3'b000, 1'b1, 1'b0, "R9");
        wr_end();
        wait_until(w3 + T + 4);

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 5000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule